// File: doc/BRIEF.md
# Dual-Channel Sample Pairing Monitor

This block watches the sample-valid strobes of two input channels whose samples are meant to arrive in pairs: one sample on each channel for every conversion. It does not touch the sample data. When both channels are enabled, the first accepted strobe opens a pair and the block waits for the other channel's strobe. While it waits, an optional timer counts clock cycles. If the timer reaches the programmed period first, a timeout error is raised. If the waiting channel strobes a second time before its partner arrives, an input-overflow error is raised.

Each error has a sticky flag and a one-cycle interrupt pulse. The flags stay set until the explicit clear input is pulsed. The live wait count is brought out so that software or a neighbouring block can watch how long a pair has been open. When only one channel is enabled, or none, every sample counts as a finished pair by itself. In that case nothing is tracked and no error can occur.

Top module: `sample_pair_monitor`

## Requirements
- R1: After reset, `wait_count` is 0, both error flags are 0 and both interrupt outputs are 0.
- R2: A strobe counts only when its channel enable is high. Unless both enables are high, no pair is tracked, `wait_count` stays 0, and neither error flag nor interrupt is raised.
- R3: With both channels enabled and no pair open, strobes on both channels in the same cycle complete a pair at once. The counter stays 0 and no error is raised.
- R4: With both channels enabled and no pair open, a strobe on exactly one channel opens a pair. `wait_count` is 0 after that edge. After each later edge at which the pair is still open and the timer is active, it has risen by one.
- R5: A strobe on the partner channel closes the open pair. `wait_count` is 0 after that edge and no error is raised.
- R6: The timer is active only when `tmo_enable` is 1 and `tmo_period` is non-zero. Take an edge at which the pair is open, no partner strobe is present and `wait_count + 1 >= tmo_period`. At that edge `tmo_err` is set, `tmo_irq` is high for the following cycle, `wait_count` returns to 0 and the pair is dropped. A later partner strobe then opens a new pair.
- R7: A partner strobe present at the edge where the timeout would fire closes the pair, and no timeout is raised.
- R8: A strobe on the channel that opened the pair, arriving before the partner's strobe, sets `ovf_err` and pulses `ovf_irq` for one cycle. The pair stays open and the count keeps running. If the partner strobes in the same cycle, the pair also closes.
- R9: `tmo_err` and `ovf_err` hold their value until `clr_err` is high at an edge. A new error at the same edge as a clear leaves its flag set.
- R10: If an enable drops while a pair is open, the pair is dropped and `wait_count` is 0 after that edge, with no error.
- R11: While the timer is inactive (`tmo_enable` 0 or `tmo_period` 0), an open pair never times out and `wait_count` does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Clears both sticky error flags |
| strobe_a | input | 1 | Sample-valid strobe, channel A |
| strobe_b | input | 1 | Sample-valid strobe, channel B |
| chan_en_a | input | 1 | Channel A enable |
| chan_en_b | input | 1 | Channel B enable |
| tmo_enable | input | 1 | Timeout enable |
| tmo_period | input | PERIOD_W (13) | Timeout period in cycles, 0 disables |
| wait_count | output | CNT_W (16) | Cycles spent waiting for the partner sample |
| tmo_err | output | 1 | Sticky timeout error |
| ovf_err | output | 1 | Sticky input-overflow error |
| tmo_irq | output | 1 | One-cycle timeout interrupt pulse |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The assertions assume that `tmo_period` never exceeds what `wait_count` can hold. This is guaranteed because the period field is narrower than the count. They also assume that strobes are single-cycle level samples at the clock edge, with no handshake. Enables, the period and the timeout enable may change at any edge, including while a pair is open. The random stimulus therefore changes them freely during open pairs, and keeps the period small so that timeouts, overflows and completions all occur often.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int DEF_PERIOD_W = 13;
  localparam int DEF_CNT_W    = 16;

  typedef enum logic [1:0] {
    WAIT_NONE = 2'd0,
    WAIT_A    = 2'd1,
    WAIT_B    = 2'd2
  } wait_e;

  // a strobe only counts when its channel is enabled
  function automatic logic f_accept(input logic strobe, input logic en);
    return strobe & en;
  endfunction

  // pairing is tracked only when both channels are live
  function automatic logic f_paired(input logic en_a, input logic en_b);
    return en_a & en_b;
  endfunction

endpackage

// File: rtl/pm_pair_tracker.sv
module pm_pair_tracker
  import pm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_a,
  input  logic acc_b,
  input  logic both_en,
  input  logic tmo_evt,
  output logic pending,
  output logic ev_start,
  output logic ev_close,
  output logic ev_repeat,
  output logic ev_pair_now
);

  wait_e wait_q, wait_d;

  always_comb begin
    ev_start    = 1'b0;
    ev_close    = 1'b0;
    ev_repeat   = 1'b0;
    ev_pair_now = 1'b0;
    if (!both_en) begin
      ev_close = (wait_q != WAIT_NONE);
    end else begin
      unique case (wait_q)
        WAIT_NONE: begin
          ev_start    = acc_a ^ acc_b;
          ev_pair_now = acc_a & acc_b;
        end
        WAIT_A: begin
          ev_repeat = acc_a;
          ev_close  = acc_b;
        end
        WAIT_B: begin
          ev_repeat = acc_b;
          ev_close  = acc_a;
        end
        default: ev_close = 1'b1;
      endcase
    end
  end

  always_comb begin
    wait_d = wait_q;
    if (ev_close || tmo_evt) wait_d = WAIT_NONE;
    else if (ev_start)       wait_d = acc_a ? WAIT_A : WAIT_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= WAIT_NONE;
    else        wait_q <= wait_d;
  end

  assign pending = (wait_q != WAIT_NONE);

  // R2: a lost enable leaves no pair open
  p_single_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !both_en |=> !pending);

  // R8: a repeat can only come from an open pair
  p_repeat_needs_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_repeat |-> pending);

endmodule

// File: rtl/pm_timeout_timer.sv
module pm_timeout_timer #(
  parameter int PERIOD_W = pm_pkg::DEF_PERIOD_W,
  parameter int CNT_W    = pm_pkg::DEF_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pending,
  input  logic                ev_start,
  input  logic                ev_close,
  input  logic                tmo_enable,
  input  logic [PERIOD_W-1:0] period,
  output logic [CNT_W-1:0]    count,
  output logic                tmo_evt
);

  localparam int CW = CNT_W + 1;

  function automatic logic f_active(input logic en, input logic [PERIOD_W-1:0] p);
    return en && (p != '0);
  endfunction

  // the count has reached or passed the period after this edge
  function automatic logic f_reached(input logic [CNT_W-1:0] c,
                                     input logic [PERIOD_W-1:0] p);
    return (CW'(c) + CW'(1)) >= CW'(p);
  endfunction

  logic active, hold_ok;

  assign active  = f_active(tmo_enable, period);
  assign hold_ok = pending && !ev_close;
  assign tmo_evt = hold_ok && active && f_reached(count, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   count <= '0;
    else if (ev_start || !hold_ok || tmo_evt)     count <= '0;
    else if (active)                              count <= count + CNT_W'(1);
  end

  // R4: a non-zero count means a pair is open
  p_count_needs_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> pending);

  // R5: closing a pair clears the count
  p_close_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> (count == '0));

  // R11: an inactive timer never advances
  p_idle_timer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ev_start && hold_ok) |=> (count == $past(count)));

endmodule

// File: rtl/pm_sticky_flag.sv
module pm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= set_evt;
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R9: the pulse always comes with its flag
  p_irq_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  // R9: the flag holds without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

endmodule

// File: rtl/sample_pair_monitor.sv
module sample_pair_monitor
  import pm_pkg::*;
#(
  parameter int PERIOD_W = DEF_PERIOD_W,
  parameter int CNT_W    = DEF_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_err,
  input  logic                strobe_a,
  input  logic                strobe_b,
  input  logic                chan_en_a,
  input  logic                chan_en_b,
  input  logic                tmo_enable,
  input  logic [PERIOD_W-1:0] tmo_period,
  output logic [CNT_W-1:0]    wait_count,
  output logic                tmo_err,
  output logic                ovf_err,
  output logic                tmo_irq,
  output logic                ovf_irq
);

  localparam int N_ERR = 2;

  logic acc_a, acc_b, both_en;
  logic pending, ev_start, ev_close, ev_repeat, ev_pair_now, tmo_evt;
  logic [N_ERR-1:0] err_set, err_flag, err_irq;

  assign acc_a   = f_accept(strobe_a, chan_en_a);
  assign acc_b   = f_accept(strobe_b, chan_en_b);
  assign both_en = f_paired(chan_en_a, chan_en_b);

  pm_pair_tracker u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_a       (acc_a),
    .acc_b       (acc_b),
    .both_en     (both_en),
    .tmo_evt     (tmo_evt),
    .pending     (pending),
    .ev_start    (ev_start),
    .ev_close    (ev_close),
    .ev_repeat   (ev_repeat),
    .ev_pair_now (ev_pair_now)
  );

  pm_timeout_timer #(.PERIOD_W(PERIOD_W), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (pending),
    .ev_start   (ev_start),
    .ev_close   (ev_close),
    .tmo_enable (tmo_enable),
    .period     (tmo_period),
    .count      (wait_count),
    .tmo_evt    (tmo_evt)
  );

  // index 0: timeout, index 1: overflow
  assign err_set = {ev_repeat, tmo_evt};

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    pm_sticky_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (err_set[i]),
      .clr     (clr_err),
      .flag    (err_flag[i]),
      .irq     (err_irq[i])
    );
  end

  assign tmo_err = err_flag[0];
  assign ovf_err = err_flag[1];
  assign tmo_irq = err_irq[0];
  assign ovf_irq = err_irq[1];

  // R2: a single live channel never raises an error
  p_no_err_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !both_en |=> (!ovf_irq && !tmo_irq));

  // R3: a same-cycle pair causes no overflow and leaves the count at zero
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_now |=> (!ovf_irq && wait_count == '0));

  // R6: a timeout leaves the count at zero
  p_tmo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> (wait_count == '0));

endmodule

// File: tb/test_sample_pair_monitor.sv
module test_sample_pair_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_err = 1'b0;
  logic        strobe_a = 1'b0, strobe_b = 1'b0;
  logic        chan_en_a = 1'b1, chan_en_b = 1'b1;
  logic        tmo_enable = 1'b1;
  logic [12:0] tmo_period = 13'd5;
  logic [15:0] wait_count;
  logic        tmo_err, ovf_err, tmo_irq, ovf_irq;

  sample_pair_monitor i_sample_pair_monitor (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
    .strobe_a(strobe_a), .strobe_b(strobe_b),
    .chan_en_a(chan_en_a), .chan_en_b(chan_en_b),
    .tmo_enable(tmo_enable), .tmo_period(tmo_period),
    .wait_count(wait_count), .tmo_err(tmo_err), .ovf_err(ovf_err),
    .tmo_irq(tmo_irq), .ovf_irq(ovf_irq)
  );

  always #5 clk = ~clk;

  // reference model: open side 0 none, 1 A, 2 B
  int    m_side, m_cnt;
  bit    m_tflag, m_oflag, m_tirq, m_oirq;
  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";
  bit    done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_side = 0; m_cnt = 0; m_tflag = 0; m_oflag = 0; m_tirq = 0; m_oirq = 0;
    end else begin
      bit a, b, mine, other, act;
      a = strobe_a && chan_en_a;
      b = strobe_b && chan_en_b;
      act = tmo_enable && (tmo_period != 0);
      m_tirq = 0; m_oirq = 0;
      if (clr_err) begin m_tflag = 0; m_oflag = 0; end
      if (!(chan_en_a && chan_en_b)) begin
        m_side = 0; m_cnt = 0;
      end else if (m_side == 0) begin
        if (a != b) begin m_side = a ? 1 : 2; m_cnt = 0; end
      end else begin
        mine  = (m_side == 1) ? a : b;
        other = (m_side == 1) ? b : a;
        if (mine) begin m_oflag = 1; m_oirq = 1; end
        if (other) begin
          m_side = 0; m_cnt = 0;
        end else if (act) begin
          if (m_cnt + 1 >= int'(tmo_period)) begin
            m_tflag = 1; m_tirq = 1; m_side = 0; m_cnt = 0;
          end else m_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (wait_count !== 16'(m_cnt) || tmo_err !== m_tflag || ovf_err !== m_oflag ||
          tmo_irq !== m_tirq || ovf_irq !== m_oirq) begin
        n_bad++;
        $display("FAIL %s t=%0t: got cnt=%0d te=%b oe=%b ti=%b oi=%b, expected cnt=%0d te=%b oe=%b ti=%b oi=%b",
                 tag, $time, wait_count, tmo_err, ovf_err, tmo_irq, ovf_irq,
                 m_cnt, m_tflag, m_oflag, m_tirq, m_oirq);
      end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got cycles=%0d expected < 50000", cycles);
      finish_up();
    end
  end

  task automatic tick(input logic a, input logic b, input logic c = 1'b0);
    @(negedge clk);
    #1;
    strobe_a = a; strobe_b = b; clr_err = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0);
  endtask

  initial begin
    // R1: reset values, compared each cycle while held
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    tag = "R2";
    chan_en_b = 0; tick(1, 0); tick(1, 0); tick(0, 1); tick(1, 1); idle(3);
    chan_en_a = 0; tick(1, 1); tick(1, 0); idle(2);
    chan_en_a = 1; chan_en_b = 1;

    tag = "R3";
    tick(1, 1); tick(1, 1); idle(3);

    tag = "R4_R5";
    tmo_period = 13'd5;
    tick(1, 0); idle(2); tick(0, 1); idle(2);
    tick(0, 1); idle(1); tick(1, 0); idle(2);

    tag = "R6";
    tick(0, 1); idle(7); tick(1, 0); idle(6); tick(0, 0, 1); idle(2);
    tmo_period = 13'd1; tick(1, 0); idle(3); tick(0, 0, 1); idle(1);

    tag = "R7";
    tmo_period = 13'd3;
    tick(1, 0); idle(2); tick(0, 1); idle(3);

    tag = "R8";
    tmo_period = 13'd9;
    tick(1, 0); tick(1, 0); idle(1); tick(1, 0); tick(0, 1); idle(2);
    tick(0, 1); tick(1, 1); idle(2);

    tag = "R9";
    tick(0, 0, 1); idle(1);
    tick(1, 0); tick(1, 0, 1); idle(1); tick(0, 1); idle(2);
    tick(0, 0, 1); idle(2);

    tag = "R10";
    tick(1, 0); idle(2); chan_en_b = 0; idle(2); chan_en_b = 1; tick(0, 1); idle(1);
    tick(1, 0); idle(10); tick(0, 0, 1);

    tag = "R11";
    tmo_enable = 0; tick(1, 0); idle(12); tick(0, 1); idle(2);
    tmo_enable = 1; tmo_period = 13'd0; tick(0, 1); idle(12); tick(1, 0); idle(2);

    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      logic ra, rb, rc;
      int r;
      r = int'($urandom_range(0, 99));
      ra = (r < 25); rb = (int'($urandom_range(0, 99)) < 25);
      rc = (int'($urandom_range(0, 99)) < 4);
      if (r == 50) chan_en_a = ~chan_en_a;
      if (r == 51) chan_en_b = ~chan_en_b;
      if (r == 52) tmo_enable = ~tmo_enable;
      if (r > 95) tmo_period = 13'($urandom_range(0, 6));
      if (!chan_en_a && !chan_en_b && r < 10) begin chan_en_a = 1; chan_en_b = 1; end
      tick(ra, rb, rc);
    end
    idle(3);
    finish_up();
  end

endmodule